// File: doc/BRIEF.md
# Accumulator Register-Operation Executor

This unit carries out the accumulator instructions of a small 16-bit accumulator machine. These are the instructions that need no memory operand. When the sequencer presents such an instruction word together with the strobe that marks the execute slot, the unit works out four things from the instruction's low twelve bits:

- the new accumulator value;
- the new extension flag E;
- the possibly advanced program counter;
- whether the machine should stop.

It registers all of these on the same clock edge and pulses a request that tells the sequencer to return to its first timing step.

Each of the twelve low instruction bits selects one action. The surrounding datapath supplies the current accumulator, E and program counter as inputs. It takes the registered results back on the cycle after the strobe. Words with several bits set apply every selected action at once, under a fixed priority among the accumulator writers. A word whose opcode field is not all ones, or whose top bit is set, is ignored.

Top module: `rr_exec_unit`

## Requirements
- R1: The unit is active only when `go_i` is 1, `ir_i[14:12]` is 3'b111 and `ir_i[15]` is 0. In any other cycle `acc_q`, `ext_q` and `pc_q` keep their values, and `seq_clr_q` and `stop_q` are 0 in the next cycle.
- R2: Every active cycle produces `seq_clr_q` = 1 in the following cycle. The pulse lasts exactly one cycle unless the unit is active again.
- R3: Bit 11 clears the accumulator (word 7800h) and bit 9 complements it (7200h). Bit 10 clears E (7400h) and bit 8 complements E (7100h).
- R4: Bit 5 (7020h) adds one to the accumulator, modulo 2^16.
- R5: Bit 7 (7080h) rotates right through E: the result is {E, acc[15:1]} and E takes acc[0].
- R6: Bit 6 (7040h) rotates left through E: the result is {acc[14:0], E} and E takes acc[15].
- R7: Bit 4 (7010h) advances the program counter when acc[15] is 0. Bit 3 (7008h) advances it when acc[15] is 1.
- R8: Bit 2 (7004h) advances the program counter when the accumulator is zero. Bit 1 (7002h) advances it when E is 0.
- R9: Bit 0 (7001h) makes `stop_q` 1 for the cycle after the active cycle, and leaves the accumulator, E and program counter unchanged.
- R10: With several bits set, the accumulator takes the result of the highest-ranked selected writer: clear, then complement, then rotate right, then rotate left, then increment. E takes, in order of rank, clear, complement, then the rotated-out bit. All tests and rotations use the input values.
- R11: However many skip tests pass, the program counter advances by one at most, and the increment wraps from FFFh to 000h.
- R12: While reset is held, `acc_q`, `ext_q`, `pc_q`, `stop_q` and `seq_clr_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Execute-slot strobe from the sequencer |
| ir_i | input | 16 | Instruction word |
| acc_i | input | 16 | Current accumulator |
| ext_i | input | 1 | Current E flag |
| pc_i | input | 12 | Current program counter |
| acc_q | output | 16 | Registered new accumulator |
| ext_q | output | 1 | Registered new E flag |
| pc_q | output | 12 | Registered new program counter |
| stop_q | output | 1 | One-cycle request to clear the run flag |
| seq_clr_q | output | 1 | One-cycle request to clear the sequence counter |

## Verification
A vector table runs each single-bit word with operands chosen to sit on both sides of its decision:

- sign skips with acc[15] at 0 and at 1;
- zero skips with values zero and nonzero;
- rotations with the carried-out end set, so that the E path shows up;
- the increment at FFFFh, so that the wrap shows up.

Multi-bit words separate the priority among the accumulator writers and show that several passing skips give one increment. A reference-model loop drives each single-bit word with random accumulator and E values to expose wrong bit wiring. Directed cases present the strobe without the opcode, the opcode with bit 15 set, and the opcode without the strobe, so that a broken qualifier shows up as changed outputs or a spurious pulse.

// File: rtl/rr_exec_unit.sv
module rr_exec_unit #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [15:0]   ir_i,
  input  logic [DW-1:0] acc_i,
  input  logic          ext_i,
  input  logic [AW-1:0] pc_i,
  output logic [DW-1:0] acc_q,
  output logic          ext_q,
  output logic [AW-1:0] pc_q,
  output logic          stop_q,
  output logic          seq_clr_q
);

  localparam logic [2:0] OP_REG = 3'b111;

  logic          active;
  logic [11:0]   b;
  logic [DW-1:0] acc_n;
  logic          ext_n;
  logic          skip;

  assign active = go_i && (ir_i[14:12] == OP_REG) && !ir_i[15];
  assign b      = ir_i[11:0];

  always_comb begin
    if      (b[11]) acc_n = '0;
    else if (b[9])  acc_n = ~acc_i;
    else if (b[7])  acc_n = {ext_i, acc_i[DW-1:1]};
    else if (b[6])  acc_n = {acc_i[DW-2:0], ext_i};
    else if (b[5])  acc_n = acc_i + 1'b1;
    else            acc_n = acc_i;
  end

  always_comb begin
    if      (b[10]) ext_n = 1'b0;
    else if (b[8])  ext_n = ~ext_i;
    else if (b[7])  ext_n = acc_i[0];
    else if (b[6])  ext_n = acc_i[DW-1];
    else            ext_n = ext_i;
  end

  assign skip = (b[4] && !acc_i[DW-1]) ||
                (b[3] &&  acc_i[DW-1]) ||
                (b[2] &&  (acc_i == '0)) ||
                (b[1] && !ext_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ext_q     <= 1'b0;
      pc_q      <= '0;
      stop_q    <= 1'b0;
      seq_clr_q <= 1'b0;
    end else begin
      stop_q    <= active && b[0];
      seq_clr_q <= active;
      if (active) begin
        acc_q <= acc_n;
        ext_q <= ext_n;
        pc_q  <= pc_i + {{(AW-1){1'b0}}, skip};
      end
    end
  end

endmodule

// File: rtl/rr_exec_chk.sv
module rr_exec_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go_i,
  input logic [15:0]   ir_i,
  input logic [DW-1:0] acc_i,
  input logic [AW-1:0] pc_i,
  input logic [DW-1:0] acc_q,
  input logic          ext_q,
  input logic [AW-1:0] pc_q,
  input logic          stop_q,
  input logic          seq_clr_q
);

  logic hit;
  assign hit = go_i && ir_i[14:12] == 3'b111 && !ir_i[15];

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(acc_q) && $stable(ext_q) && $stable(pc_q) && !seq_clr_q && !stop_q));

  p_clr_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> seq_clr_q);

  p_acc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ir_i[11]) |=> acc_q == '0);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ir_i[0]) |=> stop_q);

  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (pc_q == $past(pc_i) || pc_q == $past(pc_i) + 1'b1));

  p_no_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ir_i[4:1] == 4'b0000) |=> pc_q == $past(pc_i));

  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ir_i[11:5] == 7'b0000001) |=> acc_q == $past(acc_i) + 1'b1);

endmodule

bind rr_exec_unit rr_exec_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .ir_i(ir_i), .acc_i(acc_i),
  .pc_i(pc_i), .acc_q(acc_q), .ext_q(ext_q), .pc_q(pc_q),
  .stop_q(stop_q), .seq_clr_q(seq_clr_q)
);

// File: tb/tb_rr_exec_unit.sv
module tb_rr_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_i = 1'b0;
  logic [15:0] ir_i = '0;
  logic [15:0] acc_i = '0;
  logic        ext_i = 1'b0;
  logic [11:0] pc_i = '0;
  logic [15:0] acc_q;
  logic        ext_q;
  logic [11:0] pc_q;
  logic        stop_q;
  logic        seq_clr_q;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rr_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .ir_i(ir_i), .acc_i(acc_i),
    .ext_i(ext_i), .pc_i(pc_i), .acc_q(acc_q), .ext_q(ext_q), .pc_q(pc_q),
    .stop_q(stop_q), .seq_clr_q(seq_clr_q)
  );

  // {ir, acc, e, pc, exp_acc, exp_e, exp_pc, exp_stop}
  localparam int NV = 20;
  localparam logic [74:0] VEC [0:NV-1] = '{
    {16'h7800, 16'h1234, 1'b1, 12'h005, 16'h0000, 1'b1, 12'h005, 1'b0}, // R3
    {16'h7400, 16'h1234, 1'b1, 12'h005, 16'h1234, 1'b0, 12'h005, 1'b0}, // R3
    {16'h7200, 16'h00FF, 1'b0, 12'h010, 16'hFF00, 1'b0, 12'h010, 1'b0}, // R3
    {16'h7100, 16'h00FF, 1'b0, 12'h010, 16'h00FF, 1'b1, 12'h010, 1'b0}, // R3
    {16'h7020, 16'hFFFF, 1'b1, 12'h020, 16'h0000, 1'b1, 12'h020, 1'b0}, // R4
    {16'h7080, 16'h8001, 1'b0, 12'h030, 16'h4000, 1'b1, 12'h030, 1'b0}, // R5
    {16'h7040, 16'h8001, 1'b0, 12'h030, 16'h0002, 1'b1, 12'h030, 1'b0}, // R6
    {16'h7010, 16'h7FFF, 1'b0, 12'h040, 16'h7FFF, 1'b0, 12'h041, 1'b0}, // R7
    {16'h7010, 16'h8000, 1'b0, 12'h040, 16'h8000, 1'b0, 12'h040, 1'b0}, // R7
    {16'h7008, 16'h8000, 1'b1, 12'hFFF, 16'h8000, 1'b1, 12'h000, 1'b0}, // R11
    {16'h7004, 16'h0000, 1'b1, 12'h100, 16'h0000, 1'b1, 12'h101, 1'b0}, // R8
    {16'h7004, 16'h0001, 1'b1, 12'h100, 16'h0001, 1'b1, 12'h100, 1'b0}, // R8
    {16'h7002, 16'h0000, 1'b0, 12'h200, 16'h0000, 1'b0, 12'h201, 1'b0}, // R8
    {16'h7002, 16'h0000, 1'b1, 12'h200, 16'h0000, 1'b1, 12'h200, 1'b0}, // R8
    {16'h7001, 16'h5555, 1'b1, 12'h300, 16'h5555, 1'b1, 12'h300, 1'b1}, // R9
    {16'h7A00, 16'h1234, 1'b0, 12'h310, 16'h0000, 1'b0, 12'h310, 1'b0}, // R10
    {16'h7220, 16'h00F0, 1'b0, 12'h320, 16'hFF0F, 1'b0, 12'h320, 1'b0}, // R10
    {16'h70C0, 16'h0003, 1'b1, 12'h330, 16'h8001, 1'b1, 12'h330, 1'b0}, // R10
    {16'h701C, 16'h0000, 1'b0, 12'h050, 16'h0000, 1'b0, 12'h051, 1'b0}, // R11
    {16'h7480, 16'h0003, 1'b1, 12'h340, 16'h8001, 1'b0, 12'h340, 1'b0}  // R10
  };
  localparam int VREQ [0:NV-1] = '{3,3,3,3,4,5,6,7,7,11,8,8,8,8,9,10,10,10,11,10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ir, input logic [15:0] a, input logic e,
                      input logic [11:0] p, input logic g);
    @(negedge clk);
    ir_i = ir; acc_i = a; ext_i = e; pc_i = p; go_i = g;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  function automatic logic [29:0] ref_model(input logic [15:0] ir, input logic [15:0] a,
                                            input logic e, input logic [11:0] p);
    logic [15:0] na = a;
    logic ne = e;
    logic [11:0] np = p;
    case (ir[11:0])
      12'h800: na = 16'h0000;
      12'h400: ne = 1'b0;
      12'h200: na = ~a;
      12'h100: ne = ~e;
      12'h080: begin na = {e, a[15:1]}; ne = a[0]; end
      12'h040: begin na = {a[14:0], e}; ne = a[15]; end
      12'h020: na = a + 16'd1;
      12'h010: if (!a[15]) np = p + 12'd1;
      12'h008: if (a[15]) np = p + 12'd1;
      12'h004: if (a == 16'h0000) np = p + 12'd1;
      12'h002: if (!e) np = p + 12'd1;
      default: ;
    endcase
    return {na, ne, np, ir[11:0] == 12'h001};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 acc", acc_q, 0);
    chk("R12 ext", ext_q, 0);
    chk("R12 pc", pc_q, 0);
    chk("R12 stop", stop_q, 0);
    chk("R12 seqclr", seq_clr_q, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v = VEC[i];
      string r;
      r = $sformatf("R%0d row %0d", VREQ[i], i);
      step(v[74:59], v[58:43], v[42], v[41:30], 1'b1);
      chk({r, " acc"}, acc_q, v[29:14]);
      chk({r, " ext"}, ext_q, v[13]);
      chk({r, " pc"}, pc_q, v[12:1]);
      chk({r, " stop"}, stop_q, v[0]);
      chk({"R2 ", r, " seqclr"}, seq_clr_q, 1);
      @(negedge clk);
      chk("R2 pulse ends", seq_clr_q, 0);
    end

    for (int bit_i = 0; bit_i < 12; bit_i++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] ir = 16'h7000 | (16'h1 << bit_i);
        logic [15:0] a = k[0] ? 16'h0000 : 16'($urandom);
        logic e = 1'($urandom);
        logic [11:0] p = 12'($urandom);
        logic [29:0] x = ref_model(ir, a, e, p);
        step(ir, a, e, p, 1'b1);
        chk($sformatf("R3 R10 model bit %0d acc", bit_i), acc_q, x[29:14]);
        chk($sformatf("R5 R6 model bit %0d ext", bit_i), ext_q, x[13]);
        chk($sformatf("R7 R8 model bit %0d pc", bit_i), pc_q, x[12:1]);
        chk($sformatf("R9 model bit %0d stop", bit_i), stop_q, x[0]);
      end
    end

    step(16'h7001, 16'hAAAA, 1'b1, 12'h123, 1'b1);
    chk("R9 stop set", stop_q, 1);
    step(16'h7800, 16'hBEEF, 1'b0, 12'h777, 1'b0);
    chk("R1 no strobe acc", acc_q, 16'hAAAA);
    chk("R1 no strobe seqclr", seq_clr_q, 0);
    chk("R1 no strobe stop", stop_q, 0);
    step(16'hF800, 16'hBEEF, 1'b0, 12'h777, 1'b1);
    chk("R1 bit15 acc", acc_q, 16'hAAAA);
    chk("R1 bit15 pc", pc_q, 12'h123);
    chk("R1 bit15 seqclr", seq_clr_q, 0);
    step(16'h6800, 16'hBEEF, 1'b0, 12'h777, 1'b1);
    chk("R1 opcode acc", acc_q, 16'hAAAA);
    chk("R1 opcode ext", ext_q, 1);
    chk("R1 opcode seqclr", seq_clr_q, 0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset again acc", acc_q, 0);
    chk("R12 reset again pc", pc_q, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule